// File: doc/BRIEF.md
# ATA Task-File Command Issuer

This block takes one command descriptor and drives it onto the task-file register port of an ATA device, one register strobe per cycle. The descriptor carries the command opcode, a 16-bit feature, a 16-bit sector count, a 48-bit LBA, the unit number and a flag that selects 48-bit or 28-bit addressing. The issue sequence selects the device and polls the device busy line under a bounded cycle counter. It then writes the device-control register to enable interrupts, writes the parameter registers in the order the addressing mode calls for, and writes the opcode last.

A separate readback request fetches count and LBA from the task file. In 48-bit mode it does this in two passes: one with the high-order-byte control bit set and one with it clear. A host controller uses the block to launch non-packet, non-DMA commands and to collect the result address afterwards.

States:
- `ST_IDLE`: accepts `cmd_go` (which wins over `rb_go`) or `rb_go`.
- `ST_SEL`: writes the drive register.
- `ST_WAIT`: polls busy. It goes to `ST_CTL` when busy clears, or back to `ST_IDLE` with `abort` when the counter expires.
- `ST_CTL`: writes the control register.
- `ST_PARAM`: steps through the parameter writes.
- `ST_CMD`: writes the opcode, then returns to `ST_IDLE` with `done`.
- Readback in 48-bit mode: `ST_RB_HOB` → `ST_RB_HI` → `ST_RB_LOB` → `ST_RB_LO` → `ST_IDLE`.
- Readback in 28-bit mode: `ST_RB_LOB` → `ST_RB_LO` → `ST_IDLE`.

Top module: `ata_tf_issuer`

## Requirements
- R1: While reset is asserted and after it is released, `reg_wr`, `reg_rd`, `done`, `abort` and `busy` are all 0 until a request arrives.
- R2: The first write of an issue goes to address 6 (drive) with value 0xA0 | 0x40 | (unit << 4).
- R3: After the drive-select write and while `dev_bsy` is high, no register strobe is issued; the sequence resumes in the cycle after `dev_bsy` is seen low.
- R4: If `dev_bsy` stays high for TMO_CYCLES cycles in the wait, the block pulses `abort` for one cycle, returns to idle, never writes the opcode and does not raise `done`.
- R5: After the wait, the block writes the control register (address 0xE) with 0x08.
- R6: In 28-bit mode the parameter writes are, in order:
  - address 1: feature[7:0]
  - address 2: count[7:0]
  - address 3: LBA[7:0]
  - address 4: LBA[15:8]
  - address 5: LBA[23:16]
  - address 6: 0xE0 | (unit << 4) | LBA[27:24]
- R7: In 48-bit mode each of addresses 1 to 5 is written twice, high byte first, and the pass ends with drive = 0x40 | (unit << 4). The writes are, in order:
  - address 1: feature[15:8], then feature[7:0]
  - address 2: count[15:8], then count[7:0]
  - address 3: LBA[31:24], then LBA[7:0]
  - address 4: LBA[39:32], then LBA[15:8]
  - address 5: LBA[47:40], then LBA[23:16]
- R8: The opcode is written last, to address 7. `done` pulses for one cycle in the cycle after that write.
- R9: In 48-bit readback, the block first writes 0x88 to address 0xE and then reads addresses 2 to 5 into count[15:8], LBA[31:24], LBA[39:32] and LBA[47:40]. It then writes 0x08 to address 0xE and reads addresses 2 to 5 into count[7:0], LBA[7:0], LBA[15:8] and LBA[23:16]. `done` follows.
- R10: In 28-bit readback, the block writes 0x08 to address 0xE and then reads addresses 2 to 6. Count[15:8] and LBA[47:28] are zero, and LBA[27:24] is taken from bits 3:0 of the drive register.
- R11: `cmd_go` and `rb_go` are ignored while a sequence is active; the write sequence in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Start issuing the descriptor |
| rb_go | input | 1 | Start task-file readback |
| cmd_ext | input | 1 | 1 = 48-bit addressing, 0 = 28-bit |
| cmd_op | input | 8 | Command opcode |
| cmd_feat | input | 16 | Feature value |
| cmd_cnt | input | 16 | Sector count |
| cmd_lba | input | 48 | Logical block address |
| cmd_unit | input | 1 | Device unit (0 or 1) |
| dev_bsy | input | 1 | Device busy status bit |
| reg_rdata | input | 8 | Read data from the addressed register |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 4 | Register address; 0xE is device control |
| reg_wdata | output | 8 | Register write data |
| busy | output | 1 | A sequence is active |
| done | output | 1 | One-cycle completion pulse |
| abort | output | 1 | One-cycle busy-timeout pulse |
| rb_cnt | output | 16 | Count read back |
| rb_lba | output | 48 | LBA read back |

## Verification
Random descriptors in both addressing modes are issued against a device model whose parameter registers keep the previous byte alongside the current one. Each write log is compared with a bench-built order, which separates the 28-bit folding of LBA[27:24] from the 48-bit high-then-low pairs. Each issue is followed by a readback in the same mode that must return exactly the written count and LBA. This round trip shows whether the high-order-byte bit selects the right byte of each pair. Directed cases cover:
- a device that is never busy;
- a busy period that outlasts the timeout;
- extra start requests arriving during the wait;
- all-ones fields.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
    localparam int STEP_W = 4;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_FEAT = 4'h1;
    localparam logic [ADDR_W-1:0] A_CNT  = 4'h2;
    localparam logic [ADDR_W-1:0] A_SEC  = 4'h3;
    localparam logic [ADDR_W-1:0] A_CLO  = 4'h4;
    localparam logic [ADDR_W-1:0] A_CHI  = 4'h5;
    localparam logic [ADDR_W-1:0] A_DRV  = 4'h6;
    localparam logic [ADDR_W-1:0] A_CMD  = 4'h7;
    localparam logic [ADDR_W-1:0] A_CTL  = 4'hE;

    localparam logic [7:0] CTL_IEN = 8'h08;
    localparam logic [7:0] CTL_HOB = 8'h88;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SEL, ST_WAIT, ST_CTL, ST_PARAM, ST_CMD,
        ST_RB_HOB, ST_RB_HI, ST_RB_LOB, ST_RB_LO
    } tf_state_e;
endpackage

// File: rtl/tf_busy_timer.sv
module tf_busy_timer #(
    parameter int TMO_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bsy,
    output logic expired
);
    localparam int CW = $clog2(TMO_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign expired = run && bsy && (cnt == LIMIT);
endmodule

// File: rtl/tf_param_mux.sv
module tf_param_mux
    import ata_tf_pkg::*;
(
    input  logic              ext,
    input  logic [STEP_W-1:0] step,
    input  logic [15:0]       feat,
    input  logic [15:0]       cnt,
    input  logic [47:0]       lba,
    input  logic              unit,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        data,
    output logic              last
);
    always_comb begin
        addr = A_DRV;
        data = 8'h00;
        if (ext) begin
            case (step)
                4'd0: begin addr = A_FEAT; data = feat[15:8]; end
                4'd1: begin addr = A_FEAT; data = feat[7:0];  end
                4'd2: begin addr = A_CNT;  data = cnt[15:8];  end
                4'd3: begin addr = A_CNT;  data = cnt[7:0];   end
                4'd4: begin addr = A_SEC;  data = lba[31:24]; end
                4'd5: begin addr = A_SEC;  data = lba[7:0];   end
                4'd6: begin addr = A_CLO;  data = lba[39:32]; end
                4'd7: begin addr = A_CLO;  data = lba[15:8];  end
                4'd8: begin addr = A_CHI;  data = lba[47:40]; end
                4'd9: begin addr = A_CHI;  data = lba[23:16]; end
                default: begin addr = A_DRV; data = {3'b010, unit, 4'h0}; end
            endcase
        end else begin
            case (step)
                4'd0: begin addr = A_FEAT; data = feat[7:0];  end
                4'd1: begin addr = A_CNT;  data = cnt[7:0];   end
                4'd2: begin addr = A_SEC;  data = lba[7:0];   end
                4'd3: begin addr = A_CLO;  data = lba[15:8];  end
                4'd4: begin addr = A_CHI;  data = lba[23:16]; end
                default: begin addr = A_DRV; data = {3'b111, unit, lba[27:24]}; end
            endcase
        end
        last = ext ? (step == 4'd10) : (step == 4'd5);
    end
endmodule

// File: rtl/tf_rb_capture.sv
module tf_rb_capture
    import ata_tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              hi,
    input  logic              ext,
    input  logic [STEP_W-1:0] step,
    input  logic [7:0]        rdata,
    output logic [15:0]       rb_cnt,
    output logic [47:0]       rb_lba
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_cnt <= '0;
            rb_lba <= '0;
        end else if (cap) begin
            if (hi) begin
                case (step)
                    4'd0: rb_cnt[15:8]  <= rdata;
                    4'd1: rb_lba[31:24] <= rdata;
                    4'd2: rb_lba[39:32] <= rdata;
                    default: rb_lba[47:40] <= rdata;
                endcase
            end else begin
                case (step)
                    4'd0: begin
                        rb_cnt[7:0] <= rdata;
                        if (!ext) begin
                            rb_cnt[15:8]  <= 8'h00;
                            rb_lba[47:24] <= '0;
                        end
                    end
                    4'd1: rb_lba[7:0]   <= rdata;
                    4'd2: rb_lba[15:8]  <= rdata;
                    4'd3: rb_lba[23:16] <= rdata;
                    default: rb_lba[27:24] <= rdata[3:0];
                endcase
            end
        end
    end
endmodule

// File: rtl/ata_tf_issuer.sv
module ata_tf_issuer
    import ata_tf_pkg::*;
#(
    parameter int TMO_CYCLES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_go,
    input  logic        rb_go,
    input  logic        cmd_ext,
    input  logic [7:0]  cmd_op,
    input  logic [15:0] cmd_feat,
    input  logic [15:0] cmd_cnt,
    input  logic [47:0] cmd_lba,
    input  logic        cmd_unit,
    input  logic        dev_bsy,
    input  logic [7:0]  reg_rdata,
    output logic        reg_wr,
    output logic        reg_rd,
    output logic [3:0]  reg_addr,
    output logic [7:0]  reg_wdata,
    output logic        busy,
    output logic        done,
    output logic        abort,
    output logic [15:0] rb_cnt,
    output logic [47:0] rb_lba
);
    tf_state_e         st;
    logic [STEP_W-1:0] step;
    logic              d_ext, d_unit;
    logic [7:0]        d_op;
    logic [15:0]       d_feat, d_cnt;
    logic [47:0]       d_lba;
    logic              tmo;
    logic [ADDR_W-1:0] p_addr;
    logic [7:0]        p_data;
    logic              p_last;
    logic [STEP_W-1:0] rb_last;

    assign rb_last = d_ext ? 4'd3 : 4'd4;

    tf_busy_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(st == ST_WAIT), .bsy(dev_bsy), .expired(tmo)
    );

    tf_param_mux u_mux (
        .ext(d_ext), .step(step), .feat(d_feat), .cnt(d_cnt), .lba(d_lba),
        .unit(d_unit), .addr(p_addr), .data(p_data), .last(p_last)
    );

    tf_rb_capture u_cap (
        .clk(clk), .rst_n(rst_n), .cap(reg_rd), .hi(st == ST_RB_HI),
        .ext(d_ext), .step(step), .rdata(reg_rdata), .rb_cnt(rb_cnt), .rb_lba(rb_lba)
    );

    // State register, step counter, descriptor latch and pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; step <= '0; done <= 1'b0; abort <= 1'b0;
            d_ext <= 1'b0; d_unit <= 1'b0; d_op <= '0;
            d_feat <= '0; d_cnt <= '0; d_lba <= '0;
        end else begin
            done  <= 1'b0;
            abort <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    step <= '0;
                    if (cmd_go) begin
                        d_ext <= cmd_ext; d_unit <= cmd_unit; d_op <= cmd_op;
                        d_feat <= cmd_feat; d_cnt <= cmd_cnt; d_lba <= cmd_lba;
                        st <= ST_SEL;
                    end else if (rb_go) begin
                        d_ext <= cmd_ext;
                        st <= cmd_ext ? ST_RB_HOB : ST_RB_LOB;
                    end
                end
                ST_SEL: st <= ST_WAIT;
                ST_WAIT: begin
                    if (!dev_bsy) st <= ST_CTL;
                    else if (tmo) begin st <= ST_IDLE; abort <= 1'b1; end
                end
                ST_CTL: begin st <= ST_PARAM; step <= '0; end
                ST_PARAM: begin
                    if (p_last) begin st <= ST_CMD; step <= '0; end
                    else step <= step + 1'b1;
                end
                ST_CMD: begin st <= ST_IDLE; done <= 1'b1; end
                ST_RB_HOB: begin st <= ST_RB_HI; step <= '0; end
                ST_RB_HI: begin
                    if (step == 4'd3) begin st <= ST_RB_LOB; step <= '0; end
                    else step <= step + 1'b1;
                end
                ST_RB_LOB: begin st <= ST_RB_LO; step <= '0; end
                ST_RB_LO: begin
                    if (step == rb_last) begin st <= ST_IDLE; done <= 1'b1; step <= '0; end
                    else step <= step + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Register-port outputs decoded from the state
    always_comb begin
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = A_DRV; reg_wdata = 8'h00;
        unique case (st)
            ST_IDLE, ST_WAIT: ;
            ST_SEL: begin reg_wr = 1'b1; reg_addr = A_DRV; reg_wdata = {3'b111, d_unit, 4'h0}; end
            ST_CTL, ST_RB_LOB: begin reg_wr = 1'b1; reg_addr = A_CTL; reg_wdata = CTL_IEN; end
            ST_RB_HOB: begin reg_wr = 1'b1; reg_addr = A_CTL; reg_wdata = CTL_HOB; end
            ST_PARAM: begin reg_wr = 1'b1; reg_addr = p_addr; reg_wdata = p_data; end
            ST_CMD: begin reg_wr = 1'b1; reg_addr = A_CMD; reg_wdata = d_op; end
            ST_RB_HI, ST_RB_LO: begin reg_rd = 1'b1; reg_addr = A_CNT + step; end
            default: ;
        endcase
    end

    assign busy = (st != ST_IDLE);
endmodule

// File: rtl/ata_tf_issuer_chk.sv
module ata_tf_issuer_chk
    import ata_tf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input tf_state_e  st,
    input logic       cmd_go,
    input logic       dev_bsy,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [3:0] reg_addr,
    input logic       busy,
    input logic       done,
    input logic       abort
);
    p_sel_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEL) |-> (reg_wr && reg_addr == A_DRV));

    p_quiet_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> (!reg_wr && !reg_rd));

    p_abort_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (!done && !busy && $past(dev_bsy)));

    p_cmd_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CMD) |=> done);

    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(reg_wr || reg_rd));

    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && cmd_go) |=> (st != ST_SEL));
endmodule

bind ata_tf_issuer ata_tf_issuer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .cmd_go(cmd_go), .dev_bsy(dev_bsy),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .busy(busy),
    .done(done), .abort(abort)
);

// File: tb/ata_tf_issuer_tb_top.sv
module ata_tf_issuer_tb_top;
    localparam int TMO = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_go = 0, rb_go = 0, cmd_ext = 0, cmd_unit = 0, dev_bsy = 0;
    logic [7:0] cmd_op = 0;
    logic [15:0] cmd_feat = 0, cmd_cnt = 0;
    logic [47:0] cmd_lba = 0;
    logic [7:0] reg_rdata;
    logic reg_wr, reg_rd, busy, done, abort;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [15:0] rb_cnt;
    logic [47:0] rb_lba;

    int errors = 0, checks = 0;

    always #2 clk = ~clk;

    ata_tf_issuer #(.TMO_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .rb_go(rb_go), .cmd_ext(cmd_ext),
        .cmd_op(cmd_op), .cmd_feat(cmd_feat), .cmd_cnt(cmd_cnt), .cmd_lba(cmd_lba),
        .cmd_unit(cmd_unit), .dev_bsy(dev_bsy), .reg_rdata(reg_rdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .busy(busy), .done(done), .abort(abort), .rb_cnt(rb_cnt), .rb_lba(rb_lba)
    );

    // Write logger and device task-file model (current and previous byte)
    logic [3:0] log_a [0:1023];
    logic [7:0] log_d [0:1023];
    int log_n = 0;
    logic [7:0] cur [1:5];
    logic [7:0] prv [1:5];
    logic [7:0] drv = 8'h00, devctl = 8'h00;

    always @(posedge clk) begin
        if (reg_wr) begin
            log_a[log_n % 1024] <= reg_addr;
            log_d[log_n % 1024] <= reg_wdata;
            log_n <= log_n + 1;
            if (reg_addr >= 4'd1 && reg_addr <= 4'd5) begin
                prv[reg_addr] <= cur[reg_addr];
                cur[reg_addr] <= reg_wdata;
            end else if (reg_addr == 4'd6) drv <= reg_wdata;
            else if (reg_addr == 4'hE) devctl <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr >= 4'd1 && reg_addr <= 4'd5)
            reg_rdata = devctl[7] ? prv[reg_addr] : cur[reg_addr];
        else if (reg_addr == 4'd6) reg_rdata = drv;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        finish_run();
    end

    task automatic wait_done(output bit got);
        got = 0;
        for (int k = 0; k < 80 && !got; k++) begin
            @(negedge clk);
            if (done) got = 1;
        end
    endtask

    task automatic run_issue(input bit ext, input logic [7:0] op, input logic [15:0] feat,
                             input logic [15:0] cnt, input logic [47:0] lba, input bit unit,
                             input int bcyc, input bit poke);
        logic [3:0] ea [0:15];
        logic [7:0] ed [0:15];
        int en, base;
        bit got;
        en = 0;
        ea[en] = 4'h6; ed[en] = {3'b111, unit, 4'h0}; en++;
        ea[en] = 4'hE; ed[en] = 8'h08; en++;
        if (ext) begin
            ea[en] = 1; ed[en] = feat[15:8]; en++;  ea[en] = 1; ed[en] = feat[7:0]; en++;
            ea[en] = 2; ed[en] = cnt[15:8];  en++;  ea[en] = 2; ed[en] = cnt[7:0];  en++;
            ea[en] = 3; ed[en] = lba[31:24]; en++;  ea[en] = 3; ed[en] = lba[7:0];  en++;
            ea[en] = 4; ed[en] = lba[39:32]; en++;  ea[en] = 4; ed[en] = lba[15:8]; en++;
            ea[en] = 5; ed[en] = lba[47:40]; en++;  ea[en] = 5; ed[en] = lba[23:16]; en++;
            ea[en] = 6; ed[en] = {3'b010, unit, 4'h0}; en++;
        end else begin
            ea[en] = 1; ed[en] = feat[7:0];  en++;
            ea[en] = 2; ed[en] = cnt[7:0];   en++;
            ea[en] = 3; ed[en] = lba[7:0];   en++;
            ea[en] = 4; ed[en] = lba[15:8];  en++;
            ea[en] = 5; ed[en] = lba[23:16]; en++;
            ea[en] = 6; ed[en] = {3'b111, unit, lba[27:24]}; en++;
        end
        ea[en] = 4'h7; ed[en] = op; en++;

        @(negedge clk);
        cmd_ext = ext; cmd_op = op; cmd_feat = feat; cmd_cnt = cnt;
        cmd_lba = lba; cmd_unit = unit; cmd_go = 1; dev_bsy = (bcyc > 0);
        base = log_n;
        for (int i = 0; i < bcyc; i++) begin
            @(negedge clk);
            cmd_go = 0; rb_go = 0;
            if (poke && i == 2) begin
                cmd_go = 1; rb_go = 1; cmd_op = ~op; cmd_ext = ~ext; cmd_lba = ~lba; cmd_unit = ~unit;
            end
        end
        if (bcyc >= 2) chk(log_n - base == 1, "R3 writes during busy", 64'(log_n - base), 64'd1);
        if (bcyc == 0) @(negedge clk);
        cmd_go = 0; rb_go = 0; dev_bsy = 0;
        wait_done(got);
        chk(got, "R8 done seen", 64'(got), 64'd1);
        chk(log_n - base == en, poke ? "R11 write count" : "R8 write count", 64'(log_n - base), 64'(en));
        for (int j = 0; j < en; j++) begin
            string r;
            if (j == 0) r = "R2 select";
            else if (j == 1) r = "R5 control";
            else if (j == en - 1) r = "R8 command last";
            else r = ext ? "R7 param 48" : "R6 param 28";
            if (poke) r = {r, " R11"};
            chk({log_a[(base + j) % 1024], log_d[(base + j) % 1024]} == {ea[j], ed[j]}, r,
                {52'd0, log_a[(base + j) % 1024], log_d[(base + j) % 1024]}, {52'd0, ea[j], ed[j]});
        end
        @(negedge clk);
        chk(!done, "R8 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic run_rb(input bit ext, input logic [15:0] ecnt, input logic [47:0] elba);
        int base;
        bit got;
        @(negedge clk);
        cmd_ext = ext; rb_go = 1; base = log_n;
        @(negedge clk);
        rb_go = 0;
        wait_done(got);
        chk(got, ext ? "R9 done" : "R10 done", 64'(got), 64'd1);
        chk(rb_cnt == ecnt, ext ? "R9 count" : "R10 count", 64'(rb_cnt), 64'(ecnt));
        chk(rb_lba == elba, ext ? "R9 lba" : "R10 lba", 64'(rb_lba), 64'(elba));
        if (ext) begin
            chk(log_n - base == 2, "R9 ctl writes", 64'(log_n - base), 64'd2);
            chk(log_d[base % 1024] == 8'h88 && log_a[base % 1024] == 4'hE, "R9 hob set",
                64'(log_d[base % 1024]), 64'h88);
            chk(log_d[(base + 1) % 1024] == 8'h08, "R9 hob clear", 64'(log_d[(base + 1) % 1024]), 64'h08);
        end else begin
            chk(log_n - base == 1 && log_d[base % 1024] == 8'h08, "R10 ctl write",
                64'(log_d[base % 1024]), 64'h08);
        end
    endtask

    initial begin
        int base;
        bit seen_abort, seen_done;
        logic [15:0] f, c;
        logic [47:0] l;
        logic [7:0] o;
        bit e, u;
        int b;
        void'($urandom(32'd20240611));
        for (int k = 1; k <= 5; k++) begin cur[k] = 8'h00; prv[k] = 8'h00; end
        repeat (3) @(negedge clk);
        chk(!reg_wr && !reg_rd && !done && !abort && !busy, "R1 in reset",
            {59'd0, reg_wr, reg_rd, done, abort, busy}, 64'd0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!reg_wr && !reg_rd && !done && !abort && !busy, "R1 after reset",
            {59'd0, reg_wr, reg_rd, done, abort, busy}, 64'd0);

        // Directed: never busy, 28-bit, unit 1
        run_issue(0, 8'hC8, 16'h0011, 16'h0022, 48'h0000_0ABC_DEF1, 1, 0, 0);
        run_rb(0, 16'h0022, 48'h0000_0ABC_DEF1);
        // Directed: all ones, 48-bit
        run_issue(1, 8'h25, 16'hFFFF, 16'hFFFF, 48'hFFFF_FFFF_FFFF, 1, 3, 0);
        run_rb(1, 16'hFFFF, 48'hFFFF_FFFF_FFFF);
        // Directed: requests during the wait are ignored
        run_issue(1, 8'h35, 16'h1234, 16'h5678, 48'h1122_3344_5566, 0, 6, 1);
        run_rb(1, 16'h5678, 48'h1122_3344_5566);

        // Directed: busy never clears -> timeout
        @(negedge clk);
        cmd_ext = 0; cmd_op = 8'hEC; cmd_unit = 0; cmd_go = 1; dev_bsy = 1; base = log_n;
        seen_abort = 0; seen_done = 0;
        for (int i = 0; i < TMO + 20; i++) begin
            @(negedge clk);
            cmd_go = 0;
            if (abort) seen_abort = 1;
            if (done) seen_done = 1;
        end
        dev_bsy = 0;
        chk(seen_abort, "R4 abort pulse", 64'(seen_abort), 64'd1);
        chk(!seen_done, "R4 no done", 64'(seen_done), 64'd0);
        chk(log_n - base == 1, "R4 no command write", 64'(log_n - base), 64'd1);
        chk(!busy, "R4 back to idle", 64'(busy), 64'd0);

        // Random descriptors with round-trip readback
        for (int n = 0; n < 12; n++) begin
            e = 1'($urandom()); u = 1'($urandom());
            f = 16'($urandom()); c = 16'($urandom()); o = 8'($urandom());
            l = {16'($urandom()), 32'($urandom())};
            b = int'($urandom() % 8);
            run_issue(e, o, f, c, l, u, b, 0);
            if (e) run_rb(1, c, l);
            else run_rb(0, {8'h00, c[7:0]}, {20'h0, l[27:0]});
        end

        finish_run();
    end
endmodule